// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits in the read path of a parallel non-volatile memory whose writes are self-timed. It looks at the active-low chip select, output strobe and write strobe, the write-in-progress flag, the byte most recently written and the data read from the array. From these it chooses what appears on the data pins. When the part is idle, a read returns the stored array byte. While a write is still running, every read returns a status pattern instead. The top bit is the inverse of the top bit of the byte being written. The next bit changes value on every new read access. Software can poll either bit to find out when the write has finished.

The block also produces the output-enable for the tri-state data pins. It drives the pins only during a genuine read cycle and keeps them floating at all other times. A read access begins on the clock where the decoded read condition first becomes true, so it counts the falling edge of either strobe when the other strobe is already low. The alternating bit is cleared whenever the busy flag is low, so each write period starts from a known phase. The status positions, the data width and what fills the remaining status bits are all parameters.

Top module: `wr_status_rdmux`

## Requirements
- R1: `dq_oe` is 1 only when `ce_n`=0, `oe_n`=0 and `we_n`=1 at the same time.
- R2: `dq_oe` is 0 whenever `ce_n` or `oe_n` is 1, whatever the value of `we_n` or `busy`. With `ce_n`=0, `oe_n`=0 and `we_n`=0 there is no read, and `dq_oe` is also 0.
- R3: During a read with `busy`=1, bit 7 of `dq_out` equals the inverse of bit 7 of `last_wr_data`. This holds for any address.
- R4: During reads with `busy`=1, bit 6 of `dq_out` is 1 on the first read access of a busy period and changes value on each later access. An access starts on the first clock at which the read condition of R1 holds after a clock where it did not.
- R5: During a read with `busy`=1, bits 5..0 of `dq_out` equal bits 5..0 of `last_wr_data` (default fill mode).
- R6: During a read with `busy`=0, `dq_out` equals `arr_rd_data` on all 8 bits. This takes effect in the same cycle that `busy` falls, even in the middle of an access.
- R7: After `busy` has been 0 for at least one clock edge, the phase of the alternating bit is cleared. The first access of the next busy period again returns bit 6 = 1. Reset clears it as well.
- R8: Bit 6 keeps one value for the whole of one access, however many clocks that access lasts.
- R9: `dq_out` is all zeros whenever `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| busy | input | 1 | Self-timed write in progress |
| last_wr_data | input | 8 | Byte of the write in progress |
| arr_rd_data | input | 8 | Data read from the array |
| dq_out | output | 8 | Data to drive on the pins |
| dq_oe | output | 1 | Enable for the tri-state data pins |

## Verification
The checker looks at every clock. It checks the pin-enable rules, the inverted top bit and the filled low bits while busy, and the true array data when idle. It also checks that bit 6 stays the same through one access and differs between consecutive accesses in one busy period. Some behaviour can only be shown by the bench's scenarios. These are the exact phase of the first access after a busy period starts, the return to array data partway through an access when the write ends, and the restart of the phase in a new write period. The bench also covers accesses made by the chip select edge as well as by the output strobe edge.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
   typedef enum logic {
      FILL_LAST  = 1'b0,
      FILL_ARRAY = 1'b1
   } fill_e;

   typedef struct packed {
      logic rd_act;
      logic rd_start;
   } rd_state_t;
endpackage

// File: rtl/wcs_rd_decode.sv
module wcs_rd_decode (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce_n,
   input  logic                oe_n,
   input  logic                we_n,
   output wcs_pkg::rd_state_t  rd_o
);
   logic rd_now;
   logic rd_q;

   assign rd_now = ~ce_n & ~oe_n & we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b0;
      else        rd_q <= rd_now;
   end

   always_comb begin
      rd_o.rd_act   = rd_now;
      rd_o.rd_start = rd_now & ~rd_q;
   end
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic start,
   output logic bit_o
);
   logic tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tog_q <= 1'b0;
      else if (!busy)  tog_q <= 1'b0;
      else if (start)  tog_q <= ~tog_q;
   end

   assign bit_o = tog_q ^ start;
endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux #(
   parameter int             DATA_W    = 8,
   parameter int             INV_BIT   = 7,
   parameter int             TGL_BIT   = 6,
   parameter wcs_pkg::fill_e FILL_MODE = wcs_pkg::FILL_LAST
) (
   input  logic              en,
   input  logic              busy,
   input  logic              tgl_bit,
   input  logic [DATA_W-1:0] last_wr_data,
   input  logic [DATA_W-1:0] arr_rd_data,
   output logic [DATA_W-1:0] dq_out
);
   logic [DATA_W-1:0] fill_src;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] sel;

   generate
      if (FILL_MODE == wcs_pkg::FILL_LAST) begin : g_fill_last
         assign fill_src = last_wr_data;
      end else begin : g_fill_arr
         assign fill_src = arr_rd_data;
      end

      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         if (i == INV_BIT) begin : g_inv
            assign status[i] = ~last_wr_data[i];
         end else if (i == TGL_BIT) begin : g_tgl
            assign status[i] = tgl_bit;
         end else begin : g_fill
            assign status[i] = fill_src[i];
         end
      end
   endgenerate

   assign sel    = busy ? status : arr_rd_data;
   assign dq_out = en ? sel : '0;
endmodule

// File: rtl/wr_status_rdmux.sv
module wr_status_rdmux #(
   parameter int             DATA_W    = 8,
   parameter int             INV_BIT   = 7,
   parameter int             TGL_BIT   = 6,
   parameter wcs_pkg::fill_e FILL_MODE = wcs_pkg::FILL_LAST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              busy,
   input  logic [DATA_W-1:0] last_wr_data,
   input  logic [DATA_W-1:0] arr_rd_data,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   localparam int MIN_W = 2;

   generate
      if (DATA_W < MIN_W) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (INV_BIT < 0 || INV_BIT >= DATA_W) begin : g_bad_inv
         $error("INV_BIT out of range");
      end
      if (TGL_BIT < 0 || TGL_BIT >= DATA_W) begin : g_bad_tgl
         $error("TGL_BIT out of range");
      end
      if (INV_BIT == TGL_BIT) begin : g_bad_same
         $error("INV_BIT and TGL_BIT must differ");
      end
   endgenerate

   wcs_pkg::rd_state_t rd;
   logic               tgl_bit;

   wcs_rd_decode u_dec (
      .clk  (clk),
      .rst_n(rst_n),
      .ce_n (ce_n),
      .oe_n (oe_n),
      .we_n (we_n),
      .rd_o (rd)
   );

   wcs_toggle u_tgl (
      .clk  (clk),
      .rst_n(rst_n),
      .busy (busy),
      .start(rd.rd_start),
      .bit_o(tgl_bit)
   );

   wcs_status_mux #(
      .DATA_W   (DATA_W),
      .INV_BIT  (INV_BIT),
      .TGL_BIT  (TGL_BIT),
      .FILL_MODE(FILL_MODE)
   ) u_mux (
      .en          (rd.rd_act),
      .busy        (busy),
      .tgl_bit     (tgl_bit),
      .last_wr_data(last_wr_data),
      .arr_rd_data (arr_rd_data),
      .dq_out      (dq_out)
   );

   assign dq_oe = rd.rd_act;
endmodule

// File: rtl/wr_status_rdmux_chk.sv
module wr_status_rdmux_chk #(
   parameter int             DATA_W    = 8,
   parameter int             INV_BIT   = 7,
   parameter int             TGL_BIT   = 6,
   parameter wcs_pkg::fill_e FILL_MODE = wcs_pkg::FILL_LAST
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              busy,
   input logic [DATA_W-1:0] last_wr_data,
   input logic [DATA_W-1:0] arr_rd_data,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe
);
   localparam int NSTAT = (INV_BIT < TGL_BIT) ? INV_BIT : TGL_BIT;

   logic rd, rd_q, busy_q, have_prev, prev_b6, in_acc_b6;
   assign rd = ~ce_n & ~oe_n & we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0; busy_q <= 1'b0; have_prev <= 1'b0;
         prev_b6 <= 1'b0; in_acc_b6 <= 1'b0;
      end else begin
         rd_q   <= rd;
         busy_q <= busy;
         if (!busy) have_prev <= 1'b0;
         else if (rd && !rd_q) begin
            have_prev <= 1'b1;
            prev_b6   <= dq_out[TGL_BIT];
         end
         in_acc_b6 <= dq_out[TGL_BIT];
      end
   end

   // R1
   a_r1_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!ce_n && !oe_n && we_n));
   // R2
   a_r2_float: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n || !we_n) |-> !dq_oe);
   // R3
   a_r3_inv_top: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && busy) |-> (dq_out[INV_BIT] == ~last_wr_data[INV_BIT]));
   // R4
   a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd && !rd_q && have_prev) |-> (dq_out[TGL_BIT] != prev_b6));
   // R5
   generate
      if (FILL_MODE == wcs_pkg::FILL_LAST && NSTAT > 0) begin : g_r5
         a_r5_fill_low: assert property (@(posedge clk) disable iff (!rst_n)
            (dq_oe && busy) |-> (dq_out[NSTAT-1:0] == last_wr_data[NSTAT-1:0]));
      end
   endgenerate
   // R6
   a_r6_true_data: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && !busy) |-> (dq_out == arr_rd_data));
   // R8
   a_r8_hold_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && rd_q && busy && busy_q) |-> (dq_out[TGL_BIT] == in_acc_b6));
   // R9
   a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> (dq_out == '0));
endmodule

bind wr_status_rdmux wr_status_rdmux_chk #(
   .DATA_W(DATA_W), .INV_BIT(INV_BIT), .TGL_BIT(TGL_BIT), .FILL_MODE(FILL_MODE)
) u_chk (.*);

// File: tb/wr_status_rdmux_tb_top.sv
module wr_status_rdmux_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
   logic [7:0] last_wr_data = 8'h00, arr_rd_data = 8'h00;
   logic [7:0] dq_out;
   logic       dq_oe;

   int n_chk = 0, n_bad = 0;
   logic exp_tog = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wr_status_rdmux dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .busy(busy), .last_wr_data(last_wr_data), .arr_rd_data(arr_rd_data),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] busy_exp(input logic t);
      return {~last_wr_data[7], t, last_wr_data[5:0]};
   endfunction

   // one read access; use_ce selects which strobe makes the edge
   task automatic do_read(input bit use_ce, input string req);
      logic [7:0] e;
      @(negedge clk);
      if (use_ce) begin oe_n = 1'b0; ce_n = 1'b0; end
      else        begin ce_n = 1'b0; oe_n = 1'b0; end
      if (busy) exp_tog = ~exp_tog;
      #1;
      e = busy ? busy_exp(exp_tog) : arr_rd_data;
      chk({req, " first cycle"}, {dq_oe, dq_out}, {1'b1, e});
      @(posedge clk); #1;
      chk({req, " R8 held"}, {dq_oe, dq_out}, {1'b1, e});
      @(posedge clk); #1;
      chk({req, " R8 held 2"}, {dq_oe, dq_out}, {1'b1, e});
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      #1;
      chk({req, " R2/R9 after"}, {dq_oe, dq_out}, 9'h000);
   endtask

   task automatic set_busy(input logic b);
      @(negedge clk);
      busy = b;
      if (!b) exp_tog = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      #1;
      chk("R9 reset", {dq_oe, dq_out}, 9'h000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R9 idle after reset", {dq_oe, dq_out}, 9'h000);
   endtask

   task automatic t_strobe_combos();
      @(negedge clk);
      arr_rd_data = 8'h5A;
      ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #1;
      chk("R2 oe high", {dq_oe, dq_out}, 9'h000);
      oe_n = 1'b0; ce_n = 1'b1; #1;
      chk("R2 ce high", {dq_oe, dq_out}, 9'h000);
      ce_n = 1'b0; we_n = 1'b0; #1;
      chk("R2 we low blocks read", {dq_oe, dq_out}, 9'h000);
      we_n = 1'b1; #1;
      chk("R1 read enabled", {dq_oe, dq_out}, {1'b1, 8'h5A});
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_normal_reads();
      arr_rd_data = 8'hC3; do_read(1'b0, "R6 idle read oe");
      arr_rd_data = 8'h3C; do_read(1'b1, "R6 idle read ce");
   endtask

   task automatic t_poll(input logic [7:0] wd, input logic [7:0] ad);
      last_wr_data = wd; arr_rd_data = ad;
      set_busy(1'b1);
      for (int k = 0; k < 4; k++)
         do_read(k[0], $sformatf("R3/R4/R5 poll %0d", k));
      set_busy(1'b0);
   endtask

   task automatic t_we_no_access();
      // a read-like strobe with write strobe low must not advance the phase
      last_wr_data = 8'h81; arr_rd_data = 8'h00;
      set_busy(1'b1);
      do_read(1'b0, "R4 first");
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
      do_read(1'b0, "R4 after ignored we-low strobe");
      set_busy(1'b0);
   endtask

   task automatic t_finish_midread();
      logic [7:0] e;
      last_wr_data = 8'h7F; arr_rd_data = 8'h96;
      set_busy(1'b1);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
      exp_tog = ~exp_tog; #1;
      e = busy_exp(exp_tog);
      chk("R3/R4 before done", {dq_oe, dq_out}, {1'b1, e});
      @(negedge clk); busy = 1'b0; exp_tog = 1'b0; #1;
      chk("R6 done mid-read", {dq_oe, dq_out}, {1'b1, 8'h96});
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
      last_wr_data = 8'hE4;
      set_busy(1'b1);
      do_read(1'b1, "R7 restart phase");
      do_read(1'b0, "R7 second");
      set_busy(1'b0);
   endtask

   initial begin
      t_reset();
      t_strobe_combos();
      t_normal_reads();
      t_poll(8'h80, 8'hFF);
      t_poll(8'h2B, 8'h11);
      t_we_no_access();
      t_finish_midread();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule